// File: doc/BRIEF.md
# Circular Trace Log Buffer

This block records one 256-bit core-state sample on every clock into a circular RAM of a power-of-two number of entries. Recording continues round the ring, overwriting the oldest entry. A wrap flag flips on every pass. A reported write-address word lets software find the newest entry.

Stored samples are read back one 64-bit dword at a time through two independent paths. The first is a debug path with a loadable log address and a data register. Loading the address starts a fetch. Every completed read of the data register advances the address by one dword and starts the next fetch, so a debugger can stream the buffer out by reading the data register again and again. The second is a direct path with its own address input and a free-running 64-bit output. Setting bit 31 of either address freezes recording, so a captured history can be inspected undisturbed.

Top module: `trace_ring_log`

## Requirements
- R1: While recording is enabled, `sample_i` is written each clock into the entry at the write pointer. The pointer then advances by one and goes from the last entry back to entry 0.
- R2: `wrap_o` inverts on each clock in which a write takes place at the last entry, and otherwise holds.
- R3: Recording is enabled only when bit 31 of `dir_addr_i` and bit 31 of the debug log address are both 0. While either is 1, the write pointer and `wr_addr_o` do not change.
- R4: In any read address, bits [IDX_W+1:2] select the entry and bits [1:0] select dword n, which is entry bits [64n+63:64n].
- R5: `wr_addr_o` holds the write pointer in bits [IDX_W-1:0] and a 1 in bit IDX_W. All bits above IDX_W are 0.
- R6: A pulse on `dbg_addr_we_i` loads `dbg_addr_wdata_i` into the debug log address (seen on `dbg_addr_o` after that edge) and starts a fetch. The addressed dword appears on `dbg_data_o` on the third rising edge after the load edge.
- R7: On the first rising edge at which `dbg_data_req_i` is low after being high, bits [IDX_W+1:0] of the debug log address increment, wrapping within that field and keeping the upper bits. A new fetch then starts with the same timing as R6.
- R8: When no debug fetch is completing, `dir_data_o` is updated from the dword addressed by `dir_addr_i`. It reflects a stable address three rising edges after the address is applied.
- R9: Synchronous reset clears the write pointer, `wrap_o`, the debug log address and both data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 256 | Core-state sample to record |
| dbg_addr_we_i | input | 1 | Load strobe for the debug log address |
| dbg_addr_wdata_i | input | 32 | Value loaded into the debug log address |
| dbg_data_req_i | input | 1 | High while the debug data register is being read |
| dbg_addr_o | output | 32 | Current debug log address |
| dbg_data_o | output | 64 | Debug data register |
| dir_addr_i | input | 32 | Direct read address |
| dir_data_o | output | 64 | Direct read data |
| wr_addr_o | output | 32 | Write-address word (pointer plus marker bit) |
| wrap_o | output | 1 | Wrap flag |

## Verification
The hardest state to reach is a buffer that has wrapped at least once and is then frozen. In that state every entry holds the latest sample written to its slot, while older samples have been overwritten. The bench records more samples than the ring holds and then freezes it through the debug address MSB. It predicts each slot's content from its own count of writes. It then streams all dwords through the auto-incrementing debug path, continuing past the end of the address field so that the field wraps. Afterwards it unfreezes, records more and freezes a second time through the direct address MSB.

// File: rtl/trace_log_pkg.sv
package trace_log_pkg;
  localparam int ENTRY_W = 256;
  localparam int DWORD_W = 64;
  localparam int ADDR_W  = 32;

  // Pick dword n (bits 64n+63:64n) of a stored entry.
  function automatic logic [DWORD_W-1:0] pick_dword(input logic [ENTRY_W-1:0] ent,
                                                     input logic [1:0] sel);
    return ent[{sel, 6'b000000} +: DWORD_W];
  endfunction

  // Step the wrapping write pointer.
  function automatic logic [15:0] ring_next(input logic [15:0] ptr, input logic [15:0] last);
    return (ptr == last) ? 16'd0 : ptr + 16'd1;
  endfunction
endpackage

// File: rtl/trace_wr_ctrl.sv
module trace_wr_ctrl #(
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  output logic [IW-1:0] wptr_o,
  output logic          wrap_o
);
  import trace_log_pkg::*;
  localparam logic [15:0] LAST16 = 16'(DEPTH - 1);

  logic at_last;
  assign at_last = (16'(wptr_o) == LAST16);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_o <= '0;
      wrap_o <= 1'b0;
    end else if (en_i) begin
      wptr_o <= IW'(ring_next(16'(wptr_o), LAST16));
      if (at_last) wrap_o <= ~wrap_o;
    end
  end
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/trace_dbg_seq.sv
module trace_dbg_seq #(
  parameter int IW = 9,
  localparam int FW = IW + 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr_we_i,
  input  logic [31:0] addr_wdata_i,
  input  logic        data_req_i,
  output logic [31:0] addr_o,
  output logic        read_end_o,
  output logic        start_o,
  output logic        reading_o,
  output logic        done_o
);
  logic req_q;
  assign read_end_o = req_q & ~data_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o    <= '0;
      req_q     <= 1'b0;
      start_o   <= 1'b0;
      reading_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      req_q     <= data_req_i;
      start_o   <= addr_we_i | read_end_o;
      reading_o <= start_o;
      done_o    <= reading_o;
      if (addr_we_i)       addr_o <= addr_wdata_i;
      else if (read_end_o) addr_o[FW-1:0] <= addr_o[FW-1:0] + FW'(1);
    end
  end
endmodule

// File: rtl/trace_ring_log.sv
module trace_ring_log #(
  parameter int DEPTH = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [255:0] sample_i,
  input  logic         dbg_addr_we_i,
  input  logic [31:0]  dbg_addr_wdata_i,
  input  logic         dbg_data_req_i,
  output logic [31:0]  dbg_addr_o,
  output logic [63:0]  dbg_data_o,
  input  logic [31:0]  dir_addr_i,
  output logic [63:0]  dir_data_o,
  output logic [31:0]  wr_addr_o,
  output logic         wrap_o
);
  import trace_log_pkg::*;
  localparam int IW = $clog2(DEPTH);

  logic          log_en;
  logic [IW-1:0] wptr;
  logic [IW-1:0] rptr_q;
  logic [255:0]  ram_q;
  logic          read_end, dbg_start, dbg_reading, dbg_done;

  assign log_en = ~dir_addr_i[31] & ~dbg_addr_o[31];

  trace_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .en_i(log_en), .wptr_o(wptr), .wrap_o(wrap_o));

  trace_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
    .clk(clk), .we_i(log_en & ~rst), .waddr_i(wptr), .wdata_i(sample_i),
    .raddr_i(rptr_q), .rdata_o(ram_q));

  trace_dbg_seq #(.IW(IW)) u_seq (
    .clk(clk), .rst(rst), .addr_we_i(dbg_addr_we_i), .addr_wdata_i(dbg_addr_wdata_i),
    .data_req_i(dbg_data_req_i), .addr_o(dbg_addr_o), .read_end_o(read_end),
    .start_o(dbg_start), .reading_o(dbg_reading), .done_o(dbg_done));

  // Debug fetch wins the single read port.
  always_ff @(posedge clk) begin
    rptr_q <= dbg_start ? dbg_addr_o[IW+1:2] : dir_addr_i[IW+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_data_o <= '0;
      dir_data_o <= '0;
    end else if (dbg_done) begin
      dbg_data_o <= pick_dword(ram_q, dbg_addr_o[1:0]);
    end else begin
      dir_data_o <= pick_dword(ram_q, dir_addr_i[1:0]);
    end
  end

  assign wr_addr_o = {{(31 - IW){1'b0}}, 1'b1, wptr};
endmodule

// File: rtl/trace_ring_log_chk.sv
module trace_ring_log_chk #(
  parameter int IW = 9,
  localparam int FW = IW + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          log_en,
  input logic [IW-1:0] wptr,
  input logic          wrap,
  input logic [31:0]   wr_addr,
  input logic          read_end,
  input logic          addr_we,
  input logic [31:0]   addr_wdata,
  input logic [31:0]   dbg_addr
);
  localparam logic [IW-1:0] LAST = {IW{1'b1}};

  p_ptr_adv_r1: assert property (@(posedge clk) disable iff (rst)
    log_en |=> wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + IW'(1)));

  p_wrap_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (log_en && wptr == LAST) |=> wrap != $past(wrap));

  p_wrap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(log_en && wptr == LAST) |=> $stable(wrap));

  p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !log_en |=> $stable(wr_addr));

  p_waddr_fmt_r5: assert property (@(posedge clk) disable iff (rst)
    wr_addr[IW] && ((wr_addr >> (IW + 1)) == 32'd0));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> dbg_addr == $past(addr_wdata));

  p_autoinc_r7: assert property (@(posedge clk) disable iff (rst)
    (read_end && !addr_we) |=>
      (dbg_addr[FW-1:0] == $past(dbg_addr[FW-1:0]) + FW'(1)) &&
      (dbg_addr[31:FW] == $past(dbg_addr[31:FW])));
endmodule

bind trace_ring_log trace_ring_log_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .log_en(log_en), .wptr(wptr), .wrap(wrap_o),
  .wr_addr(wr_addr_o), .read_end(read_end), .addr_we(dbg_addr_we_i),
  .addr_wdata(dbg_addr_wdata_i), .dbg_addr(dbg_addr_o));

// File: tb/trace_ring_log_bench.sv
module trace_ring_log_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int FIELD = DEPTH * 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] sample;
  logic         dbg_addr_we = 1'b0;
  logic [31:0]  dbg_addr_wdata = '0;
  logic         dbg_data_req = 1'b0;
  logic [31:0]  dbg_addr;
  logic [63:0]  dbg_data;
  logic [31:0]  dir_addr = '0;
  logic [63:0]  dir_data;
  logic [31:0]  wr_addr;
  logic         wrap;

  int n_cmp = 0;
  int n_bad = 0;
  int nwr = 0;
  logic m_dbg31 = 1'b0;
  logic done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_ring_log #(.DEPTH(DEPTH)) u_trace_ring_log (
    .clk(clk), .rst(rst), .sample_i(sample),
    .dbg_addr_we_i(dbg_addr_we), .dbg_addr_wdata_i(dbg_addr_wdata),
    .dbg_data_req_i(dbg_data_req), .dbg_addr_o(dbg_addr), .dbg_data_o(dbg_data),
    .dir_addr_i(dir_addr), .dir_data_o(dir_data), .wr_addr_o(wr_addr), .wrap_o(wrap));

  function automatic logic [63:0] pat(input int n, input int d);
    return {32'h5A00_0000 + 32'(d), 32'(n) * 32'd7 + 32'd1};
  endfunction

  assign sample = {pat(nwr, 3), pat(nwr, 2), pat(nwr, 1), pat(nwr, 0)};

  // Write-count model: follows R1/R3 from the bench's own view of the addresses.
  always @(posedge clk) begin
    if (rst) begin
      nwr <= 0;
      m_dbg31 <= 1'b0;
    end else begin
      if (!dir_addr[31] && !m_dbg31) nwr <= nwr + 1;
      if (dbg_addr_we) m_dbg31 <= dbg_addr_wdata[31];
    end
  end

  // Expected dword for an address, given total writes (R4 decoding).
  function automatic logic [63:0] exp_word(input int total, input logic [31:0] a);
    int s, d, n;
    s = int'(a[4:2]);
    d = int'(a[1:0]);
    n = ((total - 1 - s) / DEPTH) * DEPTH + s;
    return pat(n, d);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_dbg(input logic [31:0] a);
    dbg_addr_we = 1'b1;
    dbg_addr_wdata = a;
    cyc(1);
    dbg_addr_we = 1'b0;
  endtask

  task automatic pulse_read();
    dbg_data_req = 1'b1;
    cyc(2);
    dbg_data_req = 1'b0;
    cyc(5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int frozen_n;
    logic [31:0] a;
    logic [31:0] held;
    cyc(4);
    // R9 reset state, R5 format
    chk("R9 wr_addr after reset", 64'(wr_addr), 64'(DEPTH));
    chk("R9 wrap after reset", 64'(wrap), 64'd0);
    chk("R9 dbg_addr after reset", 64'(dbg_addr), 64'd0);
    chk("R9 dbg_data after reset", dbg_data, 64'd0);
    rst = 1'b0;

    // Record past one wrap, then freeze through the debug MSB (R3).
    cyc(21);
    load_dbg(32'h8000_0009);
    frozen_n = nwr;
    cyc(3);
    chk("R1 R5 wr_addr after logging", 64'(wr_addr), 64'(DEPTH + frozen_n % DEPTH));
    chk("R2 wrap after logging", 64'(wrap), 64'((frozen_n / DEPTH) % 2));
    chk("R6 dbg_addr loaded", 64'(dbg_addr), 64'h8000_0009);
    chk("R6 dbg_data first fetch", dbg_data, exp_word(frozen_n, 32'h9));
    held = wr_addr;
    cyc(10);
    chk("R3 frozen by debug MSB", 64'(wr_addr), 64'(held));
    chk("R3 model count frozen", 64'(nwr), 64'(frozen_n));

    // Stream through the debug path past the field wrap (R7, R4).
    a = 32'h8000_0009;
    for (int k = 0; k < FIELD + 2; k++) begin
      pulse_read();
      a[4:0] = a[4:0] + 5'd1;
      chk("R7 auto-increment address", 64'(dbg_addr), 64'(a));
      chk("R7 R4 streamed dword", dbg_data, exp_word(frozen_n, a));
    end

    // Direct path sweep (R8, R4).
    for (int j = 0; j < FIELD; j++) begin
      dir_addr = 32'(j);
      cyc(5);
      chk("R8 R4 direct dword", dir_data, exp_word(frozen_n, dir_addr));
    end

    // Unfreeze, record more, freeze through the direct MSB.
    dir_addr = 32'h0;
    load_dbg(32'h0000_0000);
    cyc(13);
    dir_addr = 32'h8000_0000;
    cyc(1);
    frozen_n = nwr;
    cyc(2);
    chk("R1 wr_addr second phase", 64'(wr_addr), 64'(DEPTH + frozen_n % DEPTH));
    chk("R2 wrap second phase", 64'(wrap), 64'((frozen_n / DEPTH) % 2));
    held = wr_addr;
    cyc(10);
    chk("R3 frozen by direct MSB", 64'(wr_addr), 64'(held));
    for (int j = 0; j < FIELD; j += 3) begin
      dir_addr = 32'h8000_0000 | 32'(j);
      cyc(5);
      chk("R8 R4 direct dword while frozen", dir_data, exp_word(frozen_n, dir_addr));
    end

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule